// File: doc/BRIEF.md
# Dual-Bus Memory Port Arbiter

This block sits in front of one storage module that hangs on two parallel memory buses, called A and B. Either bus may present a read or a write at any time, each with a word address, a 16-bit data word and a pair of byte enables. The arbiter admits one request per memory cycle to the single-ported storage array behind it. When both buses ask in the same clock, bus A is served first. The request from bus B waits and is served as soon as the cycle in progress ends.

Each stored word carries one odd parity bit for each byte. On a write the arbiter forms those bits and passes them to the array with the byte enables, so a byte can be updated together with its own check bit. On a read it recomputes parity for each byte and returns, only to the bus being served, the data, one error bit per byte and a combined error flag.

A memory cycle lasts `CYCLE_CLKS` clocks (at least 2). The array is expected to capture a command on the clock edge after `mem_en` and to present its registered read word from then until its next command.

Top module: `dbus_mem_arb`

## Requirements
- R1: After reset both acknowledges, `mem_en`, both read-data outputs and all error outputs are 0.
- R2: When both buses hold a request at the clock edge that starts a memory cycle, the cycle carries bus A's address, direction and data.
- R3: A waiting request stays pending and no new cycle starts until the current one ends; `mem_en` pulses are spaced at least `CYCLE_CLKS`+1 clocks apart, so with `CYCLE_CLKS`=3 a lone request is acknowledged 4 clocks after it is raised and the losing bus of a tie after 8.
- R4: `mem_en` is high for exactly one clock, and the served bus's acknowledge is a one-clock pulse exactly `CYCLE_CLKS` clocks after that `mem_en` pulse.
- R5: On a write, `mem_wdata[15:0]` is the bus data and `mem_wdata[16+k]` is the odd parity bit of byte k (byte 0 = bits 7:0, byte 1 = bits 15:8), so that each byte together with its bit holds an odd count of ones; `mem_be` and `mem_addr` are the bus's.
- R6: A read returns on the served bus's read-data output the 16-bit word stored at the address.
- R7: On a read, error bit k of the served bus's per-byte error output is 1 exactly when byte k and stored parity bit `16+k` together hold an even count of ones.
- R8: The combined error flag of the served bus is the OR of its per-byte error bits.
- R9: The bus that is not served sees no acknowledge and keeps its read data and error outputs unchanged.
- R10: A write clears the served bus's error outputs and leaves its read data unchanged.
- R11: A byte-enabled write changes only the enabled bytes and their parity bits; the other byte and its error status are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_req | input | 1 | Bus A request, held until acknowledged |
| a_we | input | 1 | Bus A direction, 1 = write |
| a_addr | input | ADDR_W | Bus A word address |
| a_wdata | input | DATA_W | Bus A write data |
| a_be | input | DATA_W/8 | Bus A byte enables |
| a_ack | output | 1 | Bus A one-clock acknowledge |
| a_rdata | output | DATA_W | Bus A read data |
| a_perr | output | DATA_W/8 | Bus A per-byte parity errors |
| a_err | output | 1 | Bus A combined parity error |
| b_req | input | 1 | Bus B request, held until acknowledged |
| b_we | input | 1 | Bus B direction, 1 = write |
| b_addr | input | ADDR_W | Bus B word address |
| b_wdata | input | DATA_W | Bus B write data |
| b_be | input | DATA_W/8 | Bus B byte enables |
| b_ack | output | 1 | Bus B one-clock acknowledge |
| b_rdata | output | DATA_W | Bus B read data |
| b_perr | output | DATA_W/8 | Bus B per-byte parity errors |
| b_err | output | 1 | Bus B combined parity error |
| mem_en | output | 1 | Array command strobe, one clock |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array word address |
| mem_be | output | DATA_W/8 | Array byte enables |
| mem_wdata | output | DATA_W+DATA_W/8 | Array write word, parity bits above data |
| mem_rdata | input | DATA_W+DATA_W/8 | Array read word, parity bits above data |

## Verification
On every clock the assertions watch the timing skeleton: single-clock strobes and acknowledges, the minimum spacing between memory cycles, the fixed distance from strobe to acknowledge, bus A winning a tie, and odd parity on each written byte. Whether the right word comes back, whether a corrupted byte raises exactly its own error bit, and whether partial writes keep the other byte intact can only be shown by the bench's scenarios, which keep a model of the array, flip stored bits on purpose and mix contended and lone transfers.

// File: rtl/dbus_arb_pkg.sv
package dbus_arb_pkg;
  localparam int NPORTS = 2;
  localparam int PIDX_W = 1;
  localparam int BYTE_W = 8;
  localparam logic [PIDX_W-1:0] PORT_A = 1'b0;
  localparam logic [PIDX_W-1:0] PORT_B = 1'b1;
endpackage

// File: rtl/dbus_prio_sel.sv
module dbus_prio_sel #(
  parameter int N   = 2,
  parameter int IDX_W = 1
) (
  input  logic [N-1:0]     req,
  output logic             vld,
  output logic [IDX_W-1:0] idx
);
  // Lowest index has the highest priority.
  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        vld = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dbus_cycle_ctl.sv
module dbus_cycle_ctl #(
  parameter int CYCLE_CLKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic start,
  output logic done
);
  localparam int CNT_W = (CYCLE_CLKS > 2) ? $clog2(CYCLE_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_CLKS - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;

  assign start = !busy && go;
  assign done  = busy && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dbus_par_gen.sv
module dbus_par_gen import dbus_arb_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]        data,
  output logic [DATA_W/BYTE_W-1:0] par
);
  localparam int NB = DATA_W / BYTE_W;
  for (genvar k = 0; k < NB; k++) begin : g_byte
    assign par[k] = ~^data[k*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/dbus_par_chk.sv
module dbus_par_chk import dbus_arb_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]        data,
  input  logic [DATA_W/BYTE_W-1:0] par,
  output logic [DATA_W/BYTE_W-1:0] err
);
  localparam int NB = DATA_W / BYTE_W;
  for (genvar k = 0; k < NB; k++) begin : g_byte
    assign err[k] = ~(^{par[k], data[k*BYTE_W +: BYTE_W]});
  end
endmodule

// File: rtl/dbus_port_resp.sv
module dbus_port_resp #(
  parameter int DATA_W = 16,
  parameter int NB     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serve,
  input  logic              is_rd,
  input  logic [DATA_W-1:0] rd_in,
  input  logic [NB-1:0]     perr_in,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [NB-1:0]     perr,
  output logic              err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      rdata <= '0;
      perr  <= '0;
      err   <= 1'b0;
    end else begin
      ack <= serve;
      if (serve) begin
        if (is_rd) begin
          rdata <= rd_in;
          perr  <= perr_in;
          err   <= |perr_in;
        end else begin
          perr <= '0;
          err  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dbus_mem_arb.sv
module dbus_mem_arb import dbus_arb_pkg::*; #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 16,
  parameter int CYCLE_CLKS = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             a_req,
  input  logic                             a_we,
  input  logic [ADDR_W-1:0]                a_addr,
  input  logic [DATA_W-1:0]                a_wdata,
  input  logic [DATA_W/8-1:0]              a_be,
  output logic                             a_ack,
  output logic [DATA_W-1:0]                a_rdata,
  output logic [DATA_W/8-1:0]              a_perr,
  output logic                             a_err,
  input  logic                             b_req,
  input  logic                             b_we,
  input  logic [ADDR_W-1:0]                b_addr,
  input  logic [DATA_W-1:0]                b_wdata,
  input  logic [DATA_W/8-1:0]              b_be,
  output logic                             b_ack,
  output logic [DATA_W-1:0]                b_rdata,
  output logic [DATA_W/8-1:0]              b_perr,
  output logic                             b_err,
  output logic                             mem_en,
  output logic                             mem_we,
  output logic [ADDR_W-1:0]                mem_addr,
  output logic [DATA_W/8-1:0]              mem_be,
  output logic [DATA_W+DATA_W/8-1:0]       mem_wdata,
  input  logic [DATA_W+DATA_W/8-1:0]       mem_rdata
);
  localparam int NB = DATA_W / BYTE_W;

  // Port-indexed views of the two buses (index 0 = A).
  logic [NPORTS-1:0]             req_v, we_v;
  logic [NPORTS-1:0][ADDR_W-1:0] addr_v;
  logic [NPORTS-1:0][DATA_W-1:0] wd_v;
  logic [NPORTS-1:0][NB-1:0]     be_v;

  assign req_v  = {b_req, a_req};
  assign we_v   = {b_we, a_we};
  assign addr_v = {b_addr, a_addr};
  assign wd_v   = {b_wdata, a_wdata};
  assign be_v   = {b_be, a_be};

  logic              sel_vld;
  logic [PIDX_W-1:0] sel_idx;
  logic              start, done;
  logic [NB-1:0]     gen_par, chk_err;
  logic [PIDX_W-1:0] own;
  logic              own_we;

  dbus_prio_sel #(.N(NPORTS), .IDX_W(PIDX_W)) prio_i (
    .req (req_v),
    .vld (sel_vld),
    .idx (sel_idx)
  );

  dbus_cycle_ctl #(.CYCLE_CLKS(CYCLE_CLKS)) ctl_i (
    .clk   (clk),
    .rst   (rst),
    .go    (sel_vld),
    .start (start),
    .done  (done)
  );

  dbus_par_gen #(.DATA_W(DATA_W)) pgen_i (
    .data (wd_v[sel_idx]),
    .par  (gen_par)
  );

  dbus_par_chk #(.DATA_W(DATA_W)) pchk_i (
    .data (mem_rdata[DATA_W-1:0]),
    .par  (mem_rdata[DATA_W +: NB]),
    .err  (chk_err)
  );

  // Array command register, loaded when a cycle is granted.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      own       <= PORT_A;
      own_we    <= 1'b0;
    end else begin
      mem_en <= start;
      if (start) begin
        own       <= sel_idx;
        own_we    <= we_v[sel_idx];
        mem_we    <= we_v[sel_idx];
        mem_addr  <= addr_v[sel_idx];
        mem_be    <= be_v[sel_idx];
        mem_wdata <= {gen_par, wd_v[sel_idx]};
      end
    end
  end

  logic [NPORTS-1:0]             ack_v, err_v;
  logic [NPORTS-1:0][DATA_W-1:0] rd_v;
  logic [NPORTS-1:0][NB-1:0]     perr_v;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    dbus_port_resp #(.DATA_W(DATA_W), .NB(NB)) resp_i (
      .clk     (clk),
      .rst     (rst),
      .serve   (done && (own == PIDX_W'(p))),
      .is_rd   (!own_we),
      .rd_in   (mem_rdata[DATA_W-1:0]),
      .perr_in (chk_err),
      .ack     (ack_v[p]),
      .rdata   (rd_v[p]),
      .perr    (perr_v[p]),
      .err     (err_v[p])
    );
  end

  assign a_ack   = ack_v[0];
  assign a_rdata = rd_v[0];
  assign a_perr  = perr_v[0];
  assign a_err   = err_v[0];
  assign b_ack   = ack_v[1];
  assign b_rdata = rd_v[1];
  assign b_perr  = perr_v[1];
  assign b_err   = err_v[1];
endmodule

// File: rtl/dbus_mem_arb_chk.sv
module dbus_mem_arb_chk #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 16,
  parameter int CYCLE_CLKS = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       a_req,
  input logic                       a_we,
  input logic [ADDR_W-1:0]          a_addr,
  input logic                       b_req,
  input logic                       b_we,
  input logic [ADDR_W-1:0]          b_addr,
  input logic                       a_ack,
  input logic                       b_ack,
  input logic [DATA_W/8-1:0]        a_perr,
  input logic                       a_err,
  input logic [DATA_W/8-1:0]        b_perr,
  input logic                       b_err,
  input logic                       mem_en,
  input logic                       mem_we,
  input logic [ADDR_W-1:0]          mem_addr,
  input logic [DATA_W+DATA_W/8-1:0] mem_wdata
);
  localparam int NB  = DATA_W / 8;
  localparam int GW  = $clog2(CYCLE_CLKS + 2) + 1;
  localparam logic [GW-1:0] GMAX = '1;

  // Clocks since the last strobe, saturating.
  logic [GW-1:0] since_en;
  always_ff @(posedge clk) begin
    if (rst)              since_en <= GMAX;
    else if (mem_en)      since_en <= '0;
    else if (since_en != GMAX) since_en <= since_en + 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !a_ack && !b_ack && !mem_en); // R1
  AST_A_WINS_ADDR: assert property (@(posedge clk) disable iff (rst) (mem_en && $past(a_req)) |-> (mem_addr == $past(a_addr) && mem_we == $past(a_we))); // R2
  AST_B_WHEN_ALONE: assert property (@(posedge clk) disable iff (rst) (mem_en && !$past(a_req)) |-> (mem_addr == $past(b_addr) && mem_we == $past(b_we))); // R2
  AST_CYCLE_SPACING: assert property (@(posedge clk) disable iff (rst) mem_en |-> (since_en >= GW'(CYCLE_CLKS))); // R3
  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst) a_ack |-> $past(a_req)); // R3
  AST_EN_PULSE: assert property (@(posedge clk) disable iff (rst) mem_en |=> !mem_en); // R4
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst) (a_ack || b_ack) |=> (!a_ack && !b_ack)); // R4
  AST_ACK_DELAY: assert property (@(posedge clk) disable iff (rst) (a_ack || b_ack) |-> (since_en == GW'(CYCLE_CLKS - 1))); // R4
  AST_A_ERR_OR: assert property (@(posedge clk) disable iff (rst) a_ack |-> (a_err == |a_perr)); // R8
  AST_B_ERR_OR: assert property (@(posedge clk) disable iff (rst) b_ack |-> (b_err == |b_perr)); // R8
  AST_ONE_ACK: assert property (@(posedge clk) disable iff (rst) $onehot0({a_ack, b_ack})); // R9

  for (genvar k = 0; k < NB; k++) begin : g_wpar
    AST_WR_ODD_PAR: assert property (@(posedge clk) disable iff (rst) (mem_en && mem_we) |-> ^{mem_wdata[DATA_W+k], mem_wdata[k*8 +: 8]}); // R5
  end
endmodule

bind dbus_mem_arb dbus_mem_arb_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYCLE_CLKS(CYCLE_CLKS)
) chk_i (
  .clk(clk), .rst(rst),
  .a_req(a_req), .a_we(a_we), .a_addr(a_addr),
  .b_req(b_req), .b_we(b_we), .b_addr(b_addr),
  .a_ack(a_ack), .b_ack(b_ack),
  .a_perr(a_perr), .a_err(a_err), .b_perr(b_perr), .b_err(b_err),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/dbus_mem_arb_tb_top.sv
`timescale 1ns/1ps
module dbus_mem_arb_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int C  = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          a_req = 0, a_we = 0, b_req = 0, b_we = 0;
  logic [AW-1:0] a_addr = 0, b_addr = 0;
  logic [DW-1:0] a_wdata = 0, b_wdata = 0;
  logic [1:0]    a_be = 0, b_be = 0;
  logic          a_ack, b_ack, a_err, b_err;
  logic [DW-1:0] a_rdata, b_rdata;
  logic [1:0]    a_perr, b_perr;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_be;
  logic [17:0]   mem_wdata;
  logic [17:0]   mem_rdata;

  dbus_mem_arb #(.ADDR_W(AW), .DATA_W(DW), .CYCLE_CLKS(C)) dut_i (
    .clk(clk), .rst(rst),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_be(a_be),
    .a_ack(a_ack), .a_rdata(a_rdata), .a_perr(a_perr), .a_err(a_err),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_be(b_be),
    .b_ack(b_ack), .b_rdata(b_rdata), .b_perr(b_perr), .b_err(b_err),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Array model: registered read, byte-enabled write, bit-flip hook.
  logic [17:0]   arr [DEPTH];
  logic          init_go = 0, flip_go = 0;
  logic [AW-1:0] flip_addr = 0;
  logic [4:0]    flip_bit = 0;
  always @(posedge clk) begin
    if (init_go) for (int i = 0; i < DEPTH; i++) arr[i] <= 18'h30000;
    if (flip_go) arr[flip_addr][flip_bit] <= ~arr[flip_addr][flip_bit];
    if (mem_en) begin
      if (mem_we) begin
        for (int k = 0; k < 2; k++) if (mem_be[k]) begin
          arr[mem_addr][k*8 +: 8] <= mem_wdata[k*8 +: 8];
          arr[mem_addr][16+k]     <= mem_wdata[16+k];
        end
      end else mem_rdata <= arr[mem_addr];
    end
  end

  // Bench-side expectations.
  logic [DW-1:0] shd [DEPTH];
  logic [1:0]    bad [DEPTH];
  logic [DW-1:0] last_rd [2];
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic odd_bit(input logic [7:0] b);
    return ~^b;
  endfunction

  task automatic set_req(input int p, input bit r, input bit we, input logic [AW-1:0] ad,
                         input logic [DW-1:0] d, input logic [1:0] be);
    if (p == 0) begin a_req = r; a_we = we; a_addr = ad; a_wdata = d; a_be = be; end
    else        begin b_req = r; b_we = we; b_addr = ad; b_wdata = d; b_be = be; end
  endtask

  function automatic logic ack_of(input int p);
    return (p == 0) ? a_ack : b_ack;
  endfunction

  task automatic xfer(input int p, input bit we, input logic [AW-1:0] ad,
                      input logic [DW-1:0] d, input logic [1:0] be, output int lat);
    logic [DW-1:0] rd, ord;
    logic [1:0] pe;
    logic e, oack;
    @(negedge clk);
    set_req(p, 1, we, ad, d, be);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ack_of(p));
    set_req(p, 0, 0, '0, '0, '0);
    rd   = (p == 0) ? a_rdata : b_rdata;
    pe   = (p == 0) ? a_perr  : b_perr;
    e    = (p == 0) ? a_err   : b_err;
    ord  = (p == 0) ? b_rdata : a_rdata;
    oack = (p == 0) ? b_ack   : a_ack;
    check(oack == 0, "R9 other port ack", oack, 0);
    check(ord == last_rd[1-p], "R9 other port rdata", ord, last_rd[1-p]);
    if (we) begin
      check(rd == last_rd[p], "R10 rdata kept on write", rd, last_rd[p]);
      check(pe == 0 && e == 0, "R10 errors cleared on write", {pe, e}, 0);
      for (int k = 0; k < 2; k++) if (be[k]) begin
        shd[ad][k*8 +: 8] = d[k*8 +: 8];
        bad[ad][k] = 1'b0;
      end
    end else begin
      check(rd == shd[ad], "R6/R11 read data", rd, shd[ad]);
      check(pe == bad[ad], "R7 per-byte error", pe, bad[ad]);
      check(e == |bad[ad], "R8 combined error", e, |bad[ad]);
      last_rd[p] = rd;
    end
  endtask

  task automatic flip(input logic [AW-1:0] ad, input int byte_i, input int bit_i);
    @(negedge clk);
    flip_addr = ad; flip_bit = 5'(byte_i*8 + bit_i); flip_go = 1;
    @(negedge clk);
    flip_go = 0;
    shd[ad][byte_i*8 + bit_i] = ~shd[ad][byte_i*8 + bit_i];
    bad[ad][byte_i] = ~bad[ad][byte_i];
  endtask

  // Monitor: parity on written words and strobe-to-acknowledge distance.
  int since = 1000;
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_en && mem_we) begin
        check(mem_wdata[16] == odd_bit(mem_wdata[7:0]), "R5 low byte parity", mem_wdata[16], odd_bit(mem_wdata[7:0]));
        check(mem_wdata[17] == odd_bit(mem_wdata[15:8]), "R5 high byte parity", mem_wdata[17], odd_bit(mem_wdata[15:8]));
      end
      if (mem_en) since = 0; else if (since < 1000) since++;
      if (a_ack || b_ack) check(since == C, "R4 strobe to ack", since, C);
    end
  end

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up();
    end
  end

  initial begin
    int la, lb;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) begin shd[i] = '0; bad[i] = '0; end
    last_rd[0] = '0; last_rd[1] = '0;
    init_go = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    init_go = 0; rst = 0;
    @(negedge clk);
    check(a_ack == 0 && b_ack == 0, "R1 acks after reset", {a_ack, b_ack}, 0);
    check(mem_en == 0, "R1 mem_en after reset", mem_en, 0);
    check(a_rdata == 0 && b_rdata == 0, "R1 rdata after reset", {a_rdata, b_rdata}, 0);
    check({a_perr, a_err, b_perr, b_err} == 0, "R1 errors after reset", {a_perr, a_err, b_perr, b_err}, 0);

    // Lone write, then lone read on the other bus.
    xfer(0, 1, 8'h05, 16'hA5C3, 2'b11, la);
    check(la == C + 1, "R3 lone latency A", la, C + 1);
    xfer(1, 0, 8'h05, 16'h0, 2'b00, lb);
    check(lb == C + 1, "R3 lone latency B", lb, C + 1);

    // Byte write: low byte only.
    xfer(0, 1, 8'h05, 16'hFF11, 2'b01, la);
    xfer(1, 0, 8'h05, 16'h0, 2'b00, lb);
    check(b_rdata == 16'hA511, "R11 upper byte kept", b_rdata, 16'hA511);

    // Tie: both request in the same clock.
    fork
      xfer(0, 0, 8'h05, 16'h0, 2'b00, la);
      xfer(1, 1, 8'h06, 16'h1234, 2'b11, lb);
    join
    check(la == C + 1, "R2 A wins tie", la, C + 1);
    check(lb == 2*C + 2, "R3 loser served next", lb, 2*C + 2);
    fork
      xfer(0, 1, 8'h07, 16'h0F0F, 2'b11, la);
      xfer(1, 0, 8'h07, 16'h0, 2'b00, lb);
    join
    check(b_rdata == 16'h0F0F, "R2 B reads A's tie write", b_rdata, 16'h0F0F);

    // Parity errors: low byte, then both, then repair low by byte write.
    flip(8'h06, 0, 3);
    xfer(0, 0, 8'h06, 16'h0, 2'b00, la);
    check(a_perr == 2'b01 && a_err, "R7 low byte error", {a_perr, a_err}, 3'b011);
    flip(8'h06, 1, 7);
    xfer(1, 0, 8'h06, 16'h0, 2'b00, lb);
    check(b_perr == 2'b11 && b_err, "R8 both bytes error", {b_perr, b_err}, 3'b111);
    xfer(0, 1, 8'h06, 16'h0055, 2'b01, la);
    xfer(0, 0, 8'h06, 16'h0, 2'b00, la);
    check(a_perr == 2'b10, "R11 repaired byte only", a_perr, 2'b10);
    xfer(1, 0, 8'hF0, 16'h0, 2'b00, lb);
    check(b_rdata == 0 && b_perr == 0, "R6 unwritten word", {b_rdata, b_perr}, 0);

    // Random mix.
    for (int it = 0; it < 300; it++) begin
      int mode = $urandom_range(0, 9);
      logic [AW-1:0] ad0 = AW'($urandom_range(0, 15));
      logic [AW-1:0] ad1 = AW'($urandom_range(0, 15));
      if (mode == 0) flip(ad0, $urandom_range(0, 1), $urandom_range(0, 7));
      else if (mode < 4) fork
        xfer(0, 1'($urandom), ad0, 16'($urandom), 2'($urandom), la);
        xfer(1, 1'($urandom), ad1, 16'($urandom), 2'($urandom), lb);
      join
      else xfer(mode & 1, 1'($urandom), ad0, 16'($urandom), 2'($urandom), la);
    end

    repeat (4) @(negedge clk);
    finished = 1;
    finish_up();
  end
endmodule